// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory port. The processor posts word writes with byte enables and carries on at once; the buffer keeps each write until memory takes it. Each slot holds one block-aligned address, a block of data and a byte mask. A new write is compared in parallel against every occupied slot. If it falls inside the block of a slot that is not currently offered to memory, it is folded into that slot. Otherwise it takes a fresh slot at the tail. A run of sequential word stores to one block therefore leaves as a single wide memory write instead of several narrow ones.

Slots leave in the order they were opened. A drain state machine has three states. `DR_IDLE` means the buffer is empty. `DR_GATHER` means the oldest slot is still open to merges and a hold timer is counting. `DR_SEND` means the oldest slot is offered on the memory port and locked against merges. The named transitions are:

- `open` (`DR_IDLE` to `DR_GATHER`): a slot becomes occupied.
- `launch` (`DR_GATHER` to `DR_SEND`): the oldest block is completely written, or a second slot is occupied, or the hold timer expires.
- `retire_more` (`DR_SEND` to `DR_GATHER`): memory accepts the block and other slots remain.
- `retire_last` (`DR_SEND` to `DR_IDLE`): memory accepts the block and the buffer becomes empty.

Top module: `merge_wbuf`

## Requirements
- R1: After reset `wr_ready` is 1 and `mem_valid` is 0.
- R2: A write whose block address equals that of an occupied slot not in `DR_SEND` is merged into that slot, and all merged words leave in one memory transfer.
- R3: When a byte is written twice before its slot drains, the later value is the one sent to memory.
- R4: A write that matches no eligible slot opens a new slot, and slots drain in the order they were opened.
- R5: `wr_ready` is 0 only when all NUM_ENT slots are occupied and the write matches no eligible slot; a matching write to a full buffer is accepted.
- R6: The slot being offered to memory takes no merges; a write to its block opens a new slot, or stalls if the buffer is full.
- R7: The drain payload is as follows. `mem_addr` is the byte address shifted right by log2 of the block size in bytes. Word k sits at `mem_data[k*DATA_W +: DATA_W]` and its enables at `mem_be[k*DATA_W/8 +: DATA_W/8]`. `mem_wmask[k]` is 1 exactly when some byte of word k was written. Unwritten bytes are 0. The word index is taken from the address bits just above the byte offset.
- R8: `launch` happens as soon as the oldest block is completely written, or a second slot is occupied. Otherwise a lone slot is offered between HOLD_CYC and HOLD_CYC+2 cycles after the write that opened it.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` stays 1 and `mem_addr`, `mem_data` and `mem_be` stay stable.
- R10: A transfer completes on a cycle with `mem_valid` and `mem_ready` both 1; that slot is freed and the next slot is offered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Processor write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data for one word |
| wr_be | input | DATA_W/8 | Byte enables of the word |
| mem_valid | output | 1 | Block offered to memory |
| mem_ready | input | 1 | Memory takes the block |
| mem_addr | output | ADDR_W-log2(WORDS*DATA_W/8) | Block address |
| mem_data | output | WORDS*DATA_W | Block data |
| mem_be | output | WORDS*DATA_W/8 | Byte enables of the block |
| mem_wmask | output | WORDS | One bit per word with any byte written |

## Verification
The hardest situation to reach is a write that arrives while its own block sits locked in `DR_SEND` and the buffer is otherwise full. There, the lock alone decides between stalling and merging. The stimulus holds `mem_ready` low so that the oldest slot stays offered. It fills the remaining slots with distinct blocks and then presents three writes: one to a new block, one to a younger occupied block, and one to the locked block. The bench expects a stall for the first, a merge for the second and a stall for the third. A second scenario writes to the locked block with free slots left and checks that the offered payload does not move.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        DR_IDLE   = 2'd0,
        DR_GATHER = 2'd1,
        DR_SEND   = 2'd2
    } drain_state_e;
endpackage

// File: rtl/wbuf_cam.sv
module wbuf_cam #(
    parameter int NUM_ENT = 4,
    parameter int TAG_W   = 28,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [TAG_W-1:0]   tag_in,
    input  logic [TAG_W-1:0]   tags [NUM_ENT],
    input  logic [NUM_ENT-1:0] occ,
    input  logic               lock_en,
    input  logic [IDX_W-1:0]   lock_idx,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx
);
    logic [NUM_ENT-1:0] match_vec;

    // one comparator per slot; the locked slot is masked out
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        assign match_vec[i] = occ[i] && (tags[i] == tag_in) &&
                              !(lock_en && (lock_idx == IDX_W'(i)));
    end

    always_comb begin
        hit     = |match_vec;
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // R2: never two eligible slots holding the same block
    always_comb begin
        assert_single_match_R2: assert ($onehot0(match_vec) || $isunknown(match_vec))
            else $error("two eligible slots match one block");
    end
endmodule

// File: rtl/wbuf_fifo_ctrl.sv
module wbuf_fifo_ctrl #(
    parameter int NUM_ENT = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_idx <= '0;
            tail_idx <= '0;
            count    <= '0;
        end else begin
            if (push) tail_idx <= wrap_inc(tail_idx);
            if (pop)  head_idx <= wrap_inc(head_idx);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign full  = (count == CNT_W'(NUM_ENT));
    assign empty = (count == '0);

    // R5: a slot is never opened in a full buffer
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10: memory never retires a slot from an empty buffer
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wbuf_drain_fsm.sv
module wbuf_drain_fsm
    import wbuf_pkg::*;
#(
    parameter int HOLD_CYC = 16,
    localparam int AGE_W   = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_occ,
    input  logic head_full,
    input  logic multi_occ,
    input  logic push,
    input  logic mem_ready,
    output logic mem_valid,
    output logic lock,
    output logic pop
);
    drain_state_e state_q, state_d;
    logic [AGE_W-1:0] age_q;
    logic             launch;

    assign launch = head_full || multi_occ || (age_q == AGE_W'(HOLD_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE:   if (any_occ) state_d = DR_GATHER;           // open
            DR_GATHER: if (launch)  state_d = DR_SEND;             // launch
            DR_SEND:   if (mem_ready)
                           state_d = (multi_occ || push) ? DR_GATHER   // retire_more
                                                         : DR_IDLE;    // retire_last
            default:   state_d = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DR_GATHER && state_d == DR_GATHER) age_q <= age_q + 1'b1;
            else                                              age_q <= '0;
        end
    end

    always_comb begin
        mem_valid = 1'b0;
        lock      = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            DR_IDLE, DR_GATHER: ;
            DR_SEND: begin
                mem_valid = 1'b1;
                lock      = 1'b1;
                pop       = mem_ready;
            end
            default: ;
        endcase
    end

    // R1: reset leaves the machine idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == DR_IDLE);
    // R8: the hold timer never passes its limit
    assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DR_GATHER |-> age_q < AGE_W'(HOLD_CYC));
    // R10: an offer is made only with an occupied slot
    assert_offer_occupied_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> any_occ);
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
    parameter int NUM_ENT  = 4,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int HOLD_CYC = 16,
    localparam int BE_W     = DATA_W / 8,
    localparam int BYTE_OFF = $clog2(BE_W),
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int BLK_OFF  = BYTE_OFF + WIDX_W,
    localparam int TAG_W    = ADDR_W - BLK_OFF,
    localparam int BLK_W    = WORDS * DATA_W,
    localparam int BLK_BE   = WORDS * BE_W,
    localparam int IDX_W    = $clog2(NUM_ENT),
    localparam int CNT_W    = $clog2(NUM_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [TAG_W-1:0]  mem_addr,
    output logic [BLK_W-1:0]  mem_data,
    output logic [BLK_BE-1:0] mem_be,
    output logic [WORDS-1:0]  mem_wmask
);
    // slot storage
    logic [TAG_W-1:0]   tag_q  [NUM_ENT];
    logic [BLK_W-1:0]   data_q [NUM_ENT];
    logic [BLK_BE-1:0]  be_q   [NUM_ENT];
    logic [NUM_ENT-1:0] occ_q;

    // control
    logic [IDX_W-1:0] head_idx, tail_idx, hit_idx;
    logic [CNT_W-1:0] count;
    logic             full, empty, hit, lock, pop;
    logic             accept, do_alloc, do_merge;

    // decoded write
    logic [TAG_W-1:0]    w_tag;
    logic [WIDX_W-1:0]   w_widx;
    logic [BLK_W-1:0]    w_data_blk;
    logic [BLK_BE-1:0]   w_be_blk;
    logic [BLK_W-1:0]    w_bitmask;
    logic [BYTE_OFF-1:0] unused_lo;

    assign w_tag      = wr_addr[ADDR_W-1:BLK_OFF];
    assign w_widx     = wr_addr[BLK_OFF-1:BYTE_OFF];
    assign unused_lo  = wr_addr[BYTE_OFF-1:0];
    assign w_data_blk = BLK_W'(wr_data) << (w_widx * DATA_W);
    assign w_be_blk   = BLK_BE'(wr_be) << (w_widx * BE_W);

    for (genvar b = 0; b < BLK_BE; b++) begin : g_bmask
        assign w_bitmask[b*8 +: 8] = {8{w_be_blk[b]}};
    end

    wbuf_cam #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_cam (
        .tag_in   (w_tag),
        .tags     (tag_q),
        .occ      (occ_q),
        .lock_en  (lock),
        .lock_idx (head_idx),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    assign wr_ready = hit || !full;
    assign accept   = wr_valid && wr_ready;
    assign do_merge = accept && hit;
    assign do_alloc = accept && !hit;

    wbuf_fifo_ctrl #(.NUM_ENT(NUM_ENT)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_alloc),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    wbuf_drain_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_occ   (!empty),
        .head_full (&be_q[head_idx]),
        .multi_occ (count > CNT_W'(1)),
        .push      (do_alloc),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .lock      (lock),
        .pop       (pop)
    );

    // per-slot update: allocate clears the block, merge overlays enabled bytes
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        logic sel_alloc, sel_merge, sel_pop;
        assign sel_alloc = do_alloc && (tail_idx == IDX_W'(i));
        assign sel_merge = do_merge && (hit_idx  == IDX_W'(i));
        assign sel_pop   = pop      && (head_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                occ_q[i]  <= 1'b0;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
                be_q[i]   <= '0;
            end else begin
                if (sel_pop) occ_q[i] <= 1'b0;
                if (sel_alloc) begin
                    occ_q[i]  <= 1'b1;
                    tag_q[i]  <= w_tag;
                    data_q[i] <= w_data_blk & w_bitmask;
                    be_q[i]   <= w_be_blk;
                end else if (sel_merge) begin
                    data_q[i] <= (data_q[i] & ~w_bitmask) | (w_data_blk & w_bitmask);
                    be_q[i]   <= be_q[i] | w_be_blk;
                end
            end
        end
    end

    // drain payload from the oldest slot
    assign mem_addr = tag_q[head_idx];
    assign mem_data = data_q[head_idx];
    assign mem_be   = be_q[head_idx];

    for (genvar k = 0; k < WORDS; k++) begin : g_wmask
        assign mem_wmask[k] = |mem_be[k*BE_W +: BE_W];
    end

    // R6/R9: an offered block is frozen until memory takes it
    assert_offer_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_data) && $stable(mem_be));
    // R6: a merge never targets the slot offered to memory
    assert_no_merge_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_merge && mem_valid |-> hit_idx != head_idx);
    // R4: a newly opened slot is always a free one
    assert_alloc_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_alloc |-> !occ_q[tail_idx]);
endmodule

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [27:0]  mem_addr;
    logic [127:0] mem_data;
    logic [15:0]  mem_be;
    logic [3:0]   mem_wmask;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    merge_wbuf dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .mem_wmask(mem_wmask)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input string req);
        int guard = 0;
        wr_addr = a; wr_data = d; wr_be = be; wr_valid = 1'b1;
        #1;
        while (!wr_ready && guard < 50) begin
            @(negedge clk); #1; guard++;
        end
        if (!wr_ready) check(1'b0, req, 0, 1);
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic probe_write(input logic [31:0] a, input logic [31:0] d,
                               input logic [3:0] be, input bit exp_rdy, input string req);
        wr_addr = a; wr_data = d; wr_be = be; wr_valid = 1'b1;
        #1;
        check(wr_ready == exp_rdy, req, wr_ready, exp_rdy);
        if (exp_rdy && wr_ready) begin
            @(posedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic take(input logic [27:0] ea, input logic [127:0] ed,
                        input logic [3:0] em, input logic [15:0] eb, input string req);
        int g = 0;
        while (!mem_valid && g < 64) begin
            @(negedge clk); g++;
        end
        check(mem_valid == 1'b1, {req, " offer"}, mem_valid, 1);
        check(mem_addr == ea,  {req, " addr"},  mem_addr,  ea);
        check(mem_data == ed,  {req, " data"},  mem_data,  ed);
        check(mem_wmask == em, {req, " wmask"}, mem_wmask, em);
        check(mem_be == eb,    {req, " be"},    mem_be,    eb);
        mem_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    task automatic t_reset();
        check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
        check(mem_valid == 1'b0, "R1 valid", mem_valid, 0);
    endtask

    // R2/R7/R8: four sequential words merge and launch on a full block
    task automatic t_merge_full();
        do_write(32'h100, 32'hA0A0_0000, 4'hF, "R2");
        do_write(32'h104, 32'hA1A1_1111, 4'hF, "R2");
        do_write(32'h108, 32'hA2A2_2222, 4'hF, "R2");
        do_write(32'h10C, 32'hA3A3_3333, 4'hF, "R2");
        @(negedge clk);
        check(mem_valid == 1'b1, "R8 full launch", mem_valid, 1);
        take(28'h10, {32'hA3A3_3333, 32'hA2A2_2222, 32'hA1A1_1111, 32'hA0A0_0000},
             4'hF, 16'hFFFF, "R2 R7");
    endtask

    // R3: later bytes win, earlier untouched bytes stay
    task automatic t_overwrite();
        do_write(32'h204, 32'h1111_2222, 4'hF, "R3");
        do_write(32'h204, 32'h3333_4444, 4'h3, "R3");
        do_write(32'h208, 32'h5555_6666, 4'hF, "R3");
        take(28'h20, {32'h0, 32'h5555_6666, 32'h1111_4444, 32'h0},
             4'b0110, 16'h0FF0, "R3 R7");
    endtask

    // R8: a lone partial slot waits for the hold timer
    task automatic t_hold();
        do_write(32'h300, 32'hDEAD_BEEF, 4'h1, "R8");
        repeat (14) @(negedge clk);
        check(mem_valid == 1'b0, "R8 hold early", mem_valid, 0);
        repeat (4) @(negedge clk);
        check(mem_valid == 1'b1, "R8 hold expiry", mem_valid, 1);
        take(28'h30, {96'h0, 32'h0000_00EF}, 4'b0001, 16'h0001, "R8 R7");
    endtask

    // R4: new blocks open new slots, drain in order, younger slot still merges
    task automatic t_order();
        do_write(32'h400, 32'h4000_0000, 4'hF, "R4");
        do_write(32'h500, 32'h5000_0000, 4'hF, "R4");
        do_write(32'h600, 32'h6000_0000, 4'hF, "R4");
        do_write(32'h504, 32'h5000_0001, 4'hF, "R4");
        take(28'h40, {96'h0, 32'h4000_0000}, 4'b0001, 16'h000F, "R4 first");
        take(28'h50, {64'h0, 32'h5000_0001, 32'h5000_0000}, 4'b0011, 16'h00FF, "R4 second");
        take(28'h60, {96'h0, 32'h6000_0000}, 4'b0001, 16'h000F, "R4 third");
    endtask

    // R5/R6: full buffer stalls new and locked blocks, merges a younger match
    task automatic t_full();
        do_write(32'h700, 32'h7000_0000, 4'hF, "R5");
        do_write(32'h800, 32'h8000_0000, 4'hF, "R5");
        do_write(32'h900, 32'h9000_0000, 4'hF, "R5");
        do_write(32'hA00, 32'hA000_0000, 4'hF, "R5");
        probe_write(32'hB00, 32'hB000_0000, 4'hF, 1'b0, "R5 stall new");
        probe_write(32'h808, 32'h8000_0002, 4'hF, 1'b1, "R5 merge when full");
        probe_write(32'h704, 32'h7000_0001, 4'hF, 1'b0, "R6 locked stall");
        take(28'h70, {96'h0, 32'h7000_0000}, 4'b0001, 16'h000F, "R6 locked");
        take(28'h80, {32'h0, 32'h8000_0002, 32'h0, 32'h8000_0000}, 4'b0101, 16'h0F0F, "R5");
        take(28'h90, {96'h0, 32'h9000_0000}, 4'b0001, 16'h000F, "R5");
        take(28'hA0, {96'h0, 32'hA000_0000}, 4'b0001, 16'h000F, "R10");
    endtask

    // R6/R9: offered block stays frozen while a write to its block opens a slot
    task automatic t_lock();
        logic [127:0] snap;
        int g = 0;
        do_write(32'hC00, 32'hC0C0_C0C0, 4'hF, "R6");
        while (!mem_valid && g < 64) begin
            @(negedge clk); g++;
        end
        snap = mem_data;
        do_write(32'hC04, 32'hC1C1_C1C1, 4'hF, "R6");
        repeat (3) @(negedge clk);
        check(mem_valid == 1'b1, "R9 valid held", mem_valid, 1);
        check(mem_data == snap, "R9 data stable", mem_data, snap);
        take(28'hC0, {96'h0, 32'hC0C0_C0C0}, 4'b0001, 16'h000F, "R6 old");
        take(28'hC0, {64'h0, 32'hC1C1_C1C1, 32'h0}, 4'b0010, 16'h00F0, "R6 R10 new");
        repeat (2) @(negedge clk);
        check(mem_valid == 1'b0, "R10 empty", mem_valid, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(1'b0, "watchdog", cycles, 100000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge_full();
        t_overwrite();
        t_hold();
        t_order();
        t_full();
        t_lock();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule